// File: doc/BRIEF.md
# Multi-Slot AES Key Store Controller

This block sits beside a cipher engine and keeps up to eight AES keys in a small on-chip memory. A key arrives as a stream of 32-bit words, typically from an input DMA channel, into the slot that a one-hot write selector points at. A key that is stored completely marks its slot valid in an eight-bit bitmap. Keys that arrive with the wrong length, or with no slot selected, leave the slot invalid and raise a write-error flag. One global key-size setting (128, 192 or 256 bits) applies to every slot, and any change to it wipes the whole store.

To load a key into the cipher core, software writes a binary slot index to start a read. If the slot is valid, the controller raises a busy flag and streams the key into the core's key register at one word per clock, then drops busy. Busy is the only sign that a read has finished. A read of an invalid slot raises a read-error flag and moves no data. Software can also drop the valid bit of one slot at a time. Three sticky flags (write error, read error, result available) are cleared by write-one-to-clear strobes.

Top module: `keystore_top`

## Requirements
- R1: After reset the valid bitmap is all zero, the key size reads 0 (128-bit), busy is low, no core key word is written, and all three flags are low.
- R2: A write-area strobe with exactly one bit n set selects slot n and clears its valid bit in the next cycle. Each following `inValid` word is stored at word index 0, 1, 2 and so on. When the last expected word arrives with `inLast` high, the slot's valid bit and `resultAvail` are both set in the next cycle. The last expected word is the 4th for key size 0, and the 8th for key size 1, 2 or 3.
- R3: With key size 1 (192-bit), word indices 6 and 7 of a slot are stored as zero whatever data arrives. Word 7 is the most significant word.
- R4: `wrErr` is set and the target slot stays invalid in three cases: `inLast` arrives before the last expected word; the last expected word arrives without `inLast`; or a word arrives while no slot is selected. No slot is selected after a key finishes, after an error, and after a selector value that is not one-hot.
- R5: A key-size write sets the size to its 2-bit encoding (0 = 128, 1 = 192, 2 = 256, 3 acts as 256). It clears every valid bit in the next cycle and ends any write in progress.
- R6: An invalidate strobe with index n clears only valid bit n in the next cycle. On a slot that is already invalid, the bitmap does not change.
- R7: A read start on a valid slot raises `rdBusy` in the next cycle for exactly 4 cycles (size 0) or 8 cycles (other sizes). During those cycles `coreKeyWe` is high and `coreKeyIdx` runs from 0 upward, with `coreKeyData` holding that word of the slot. Busy then drops.
- R8: A read start on an invalid slot sets `rdErr` in the next cycle and produces no busy and no core key write.
- R9: A read start while `rdBusy` is high is ignored: the running transfer keeps its slot and its length.
- R10: `flagClr` bit 0 clears `wrErr`, bit 1 clears `rdErr` and bit 2 clears `resultAvail`. A flag's set event in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keySizeWe | input | 1 | Key-size write strobe |
| keySizeIn | input | 2 | Key-size encoding to write |
| wrAreaWe | input | 1 | Write-area selector strobe |
| wrArea | input | 8 | One-hot slot to write |
| inValid | input | 1 | Key word present on the write stream |
| inData | input | 32 | Key word |
| inLast | input | 1 | Marks the final word of a key |
| invalidateWe | input | 1 | Single-slot invalidate strobe |
| invalidateIdx | input | 3 | Slot to invalidate |
| rdStartWe | input | 1 | Read start strobe |
| rdIdx | input | 3 | Binary slot index to read |
| flagClr | input | 3 | Write-one-to-clear for wrErr, rdErr, resultAvail |
| validMap | output | 8 | Valid bit per slot |
| keySize | output | 2 | Current key-size setting |
| rdBusy | output | 1 | Transfer to the core in progress |
| coreKeyWe | output | 1 | Core key register word write |
| coreKeyIdx | output | 3 | Word index in the core key register |
| coreKeyData | output | 32 | Key word for the core |
| wrErr | output | 1 | Sticky write-error flag |
| rdErr | output | 1 | Sticky read-error flag |
| resultAvail | output | 1 | Sticky key-stored flag |

## Verification
Every strobe takes effect at the clock edge that samples it. The bitmap, the flags and the key size therefore change one cycle after their stimulus, and the first core key word comes one cycle after a read start. The core words then follow on consecutive cycles, and busy is low again in the cycle after the last word. The bench drives inputs on the falling edge and checks at the next falling edge, so each result is read in the first cycle it is due. During a read it checks every cycle, which confirms the exact transfer length.

// File: rtl/keystore_pkg.sv
package keystore_pkg;
  localparam int KS_SLOTS     = 8;
  localparam int KS_WORD_W    = 32;
  localparam int KS_MAX_WORDS = 8;
  localparam int KS_SLOT_W    = $clog2(KS_SLOTS);
  localparam int KS_CNT_W     = $clog2(KS_MAX_WORDS);
  localparam int KS_FLAGS     = 3;

  typedef enum logic [1:0] {
    KSZ_128  = 2'd0,
    KSZ_192  = 2'd1,
    KSZ_256  = 2'd2,
    KSZ_RSVD = 2'd3
  } keySize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 ramWe;
    logic [KS_SLOT_W-1:0] ramSlot;
    logic [KS_CNT_W-1:0]  ramWord;
    logic                 ramZero;
    logic [KS_SLOTS-1:0]  setMask;
    logic [KS_SLOTS-1:0]  clrMask;
    logic                 clrAll;
    logic [KS_SLOT_W-1:0] rdSlot;
    logic [KS_CNT_W-1:0]  rdWord;
  } ksStrobe_t;

  // index of the final word of a key of the given size
  function automatic logic [KS_CNT_W-1:0] lastIdx(keySize_e s);
    return (s == KSZ_128) ? KS_CNT_W'(KS_MAX_WORDS / 2 - 1) : KS_CNT_W'(KS_MAX_WORDS - 1);
  endfunction
endpackage

// File: rtl/ks_datapath.sv
module ks_datapath
  import keystore_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ksStrobe_t            stb,
  input  logic [KS_WORD_W-1:0] wrData,
  output logic [KS_SLOTS-1:0]  validMap,
  output logic [KS_WORD_W-1:0] rdData
);
  logic [KS_WORD_W-1:0] keyRam [KS_SLOTS][KS_MAX_WORDS];

  always_ff @(posedge clk) begin
    if (stb.ramWe) keyRam[stb.ramSlot][stb.ramWord] <= stb.ramZero ? '0 : wrData;
  end

  // per-slot valid bit: clears win over a completion
  for (genvar g = 0; g < KS_SLOTS; g++) begin : gValid
    always_ff @(posedge clk) begin
      if (!rstN)                             validMap[g] <= 1'b0;
      else if (stb.clrAll || stb.clrMask[g]) validMap[g] <= 1'b0;
      else if (stb.setMask[g])               validMap[g] <= 1'b1;
    end
  end

  assign rdData = keyRam[stb.rdSlot][stb.rdWord];
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import keystore_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 keySizeWe,
  input  logic [1:0]           keySizeIn,
  input  logic                 wrAreaWe,
  input  logic [KS_SLOTS-1:0]  wrArea,
  input  logic                 inValid,
  input  logic                 inLast,
  input  logic                 invalidateWe,
  input  logic [KS_SLOT_W-1:0] invalidateIdx,
  input  logic                 rdStartWe,
  input  logic [KS_SLOT_W-1:0] rdIdx,
  input  logic [KS_FLAGS-1:0]  flagClr,
  input  logic [KS_SLOTS-1:0]  validMap,
  output ksStrobe_t            stb,
  output logic [1:0]           keySize,
  output logic                 rdBusy,
  output logic                 coreKeyWe,
  output logic [KS_CNT_W-1:0]  coreKeyIdx,
  output logic                 wrErr,
  output logic                 rdErr,
  output logic                 resultAvail
);
  keySize_e             sizeQ;
  logic                 wrActive;
  logic [KS_SLOT_W-1:0] wrSlot, rdSlot, selIdx;
  logic [KS_CNT_W-1:0]  wrCnt, rdCnt, rdLast, wrLast;
  logic                 selOk, wordAcc, wordOrphan, cntAtLast, goodEnd, badEnd;
  logic                 rdOk, rdBad;

  always_comb begin
    selIdx = '0;
    for (int i = 0; i < KS_SLOTS; i++) if (wrArea[i]) selIdx = KS_SLOT_W'(i);
  end

  assign selOk      = $onehot(wrArea);
  assign wrLast     = lastIdx(sizeQ);
  assign wordAcc    = inValid && wrActive && !wrAreaWe && !keySizeWe;
  assign wordOrphan = inValid && !wrActive && !wrAreaWe && !keySizeWe;
  assign cntAtLast  = (wrCnt == wrLast);
  assign goodEnd    = wordAcc && inLast && cntAtLast;
  assign badEnd     = wordAcc && (inLast != cntAtLast);
  assign rdOk       = rdStartWe && !rdBusy && validMap[rdIdx];
  assign rdBad      = rdStartWe && !rdBusy && !validMap[rdIdx];

  always_comb begin
    stb         = '0;
    stb.ramWe   = wordAcc;
    stb.ramSlot = wrSlot;
    stb.ramWord = wrCnt;
    stb.ramZero = (sizeQ == KSZ_192) && (wrCnt >= KS_CNT_W'(KS_MAX_WORDS - 2));
    stb.setMask = goodEnd ? (KS_SLOTS'(1) << wrSlot) : '0;
    stb.clrMask = (invalidateWe ? (KS_SLOTS'(1) << invalidateIdx) : '0)
                | ((wrAreaWe && selOk) ? wrArea : '0);
    stb.clrAll  = keySizeWe;
    stb.rdSlot  = rdSlot;
    stb.rdWord  = rdCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeQ       <= KSZ_128;
      wrActive    <= 1'b0;
      wrSlot      <= '0;
      wrCnt       <= '0;
      rdBusy      <= 1'b0;
      rdSlot      <= '0;
      rdCnt       <= '0;
      rdLast      <= '0;
      wrErr       <= 1'b0;
      rdErr       <= 1'b0;
      resultAvail <= 1'b0;
    end else begin
      if (keySizeWe) sizeQ <= keySize_e'(keySizeIn);

      if (keySizeWe) begin
        wrActive <= 1'b0;
      end else if (wrAreaWe) begin
        wrActive <= selOk;
        wrSlot   <= selIdx;
        wrCnt    <= '0;
      end else if (wordAcc) begin
        if (inLast || cntAtLast) wrActive <= 1'b0;
        wrCnt <= wrCnt + 1'b1;
      end

      if (rdBusy) begin
        rdCnt <= rdCnt + 1'b1;
        if (rdCnt == rdLast) rdBusy <= 1'b0;
      end else if (rdOk) begin
        rdBusy <= 1'b1;
        rdSlot <= rdIdx;
        rdCnt  <= '0;
        rdLast <= lastIdx(sizeQ);
      end

      wrErr       <= (wrErr & ~flagClr[0]) | badEnd | wordOrphan;
      rdErr       <= (rdErr & ~flagClr[1]) | rdBad;
      resultAvail <= (resultAvail & ~flagClr[2]) | goodEnd;
    end
  end

  assign keySize    = sizeQ;
  assign coreKeyWe  = rdBusy;
  assign coreKeyIdx = rdCnt;
endmodule

// File: rtl/keystore_top.sv
module keystore_top
  import keystore_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 keySizeWe,
  input  logic [1:0]           keySizeIn,
  input  logic                 wrAreaWe,
  input  logic [KS_SLOTS-1:0]  wrArea,
  input  logic                 inValid,
  input  logic [KS_WORD_W-1:0] inData,
  input  logic                 inLast,
  input  logic                 invalidateWe,
  input  logic [KS_SLOT_W-1:0] invalidateIdx,
  input  logic                 rdStartWe,
  input  logic [KS_SLOT_W-1:0] rdIdx,
  input  logic [KS_FLAGS-1:0]  flagClr,
  output logic [KS_SLOTS-1:0]  validMap,
  output logic [1:0]           keySize,
  output logic                 rdBusy,
  output logic                 coreKeyWe,
  output logic [KS_CNT_W-1:0]  coreKeyIdx,
  output logic [KS_WORD_W-1:0] coreKeyData,
  output logic                 wrErr,
  output logic                 rdErr,
  output logic                 resultAvail
);
  ksStrobe_t stb;

  ks_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .keySizeWe(keySizeWe), .keySizeIn(keySizeIn),
    .wrAreaWe(wrAreaWe), .wrArea(wrArea), .inValid(inValid), .inLast(inLast),
    .invalidateWe(invalidateWe), .invalidateIdx(invalidateIdx),
    .rdStartWe(rdStartWe), .rdIdx(rdIdx), .flagClr(flagClr), .validMap(validMap),
    .stb(stb), .keySize(keySize), .rdBusy(rdBusy), .coreKeyWe(coreKeyWe),
    .coreKeyIdx(coreKeyIdx), .wrErr(wrErr), .rdErr(rdErr), .resultAvail(resultAvail)
  );

  ks_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(inData),
    .validMap(validMap), .rdData(coreKeyData)
  );
endmodule

// File: rtl/keystore_checker.sv
module keystore_checker
  import keystore_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 keySizeWe,
  input logic                 inValid,
  input logic                 inLast,
  input logic                 invalidateWe,
  input logic [KS_SLOT_W-1:0] invalidateIdx,
  input logic                 rdStartWe,
  input logic [KS_SLOT_W-1:0] rdIdx,
  input logic [KS_SLOTS-1:0]  validMap,
  input logic                 rdBusy,
  input logic                 coreKeyWe,
  input logic [KS_CNT_W-1:0]  coreKeyIdx,
  input logic                 rdErr
);
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((validMap & ~$past(validMap)) != '0) |-> $past(inValid && inLast));

  assert_size_wipe_R5: assert property (@(posedge clk) disable iff (!rstN)
    keySizeWe |=> (validMap == '0));

  assert_invalidate_R6: assert property (@(posedge clk) disable iff (!rstN)
    invalidateWe |=> !validMap[$past(invalidateIdx)]);

  assert_read_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStartWe && !rdBusy && validMap[rdIdx]) |=> (rdBusy && coreKeyWe && coreKeyIdx == '0));

  assert_read_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdBusy && $past(rdBusy)) |-> (coreKeyIdx == KS_CNT_W'($past(coreKeyIdx) + 1'b1)));

  assert_read_invalid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStartWe && !rdBusy && !validMap[rdIdx]) |=> (rdErr && !rdBusy && !coreKeyWe));
endmodule

bind keystore_top keystore_checker chk_i (
  .clk(clk), .rstN(rstN), .keySizeWe(keySizeWe), .inValid(inValid), .inLast(inLast),
  .invalidateWe(invalidateWe), .invalidateIdx(invalidateIdx), .rdStartWe(rdStartWe),
  .rdIdx(rdIdx), .validMap(validMap), .rdBusy(rdBusy), .coreKeyWe(coreKeyWe),
  .coreKeyIdx(coreKeyIdx), .rdErr(rdErr)
);

// File: tb/keystore_tb.sv
`timescale 1ns/1ps
module keystore_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keySizeWe = 0, wrAreaWe = 0, inValid = 0, inLast = 0;
  logic        invalidateWe = 0, rdStartWe = 0;
  logic [1:0]  keySizeIn = 0;
  logic [7:0]  wrArea = 0;
  logic [31:0] inData = 0;
  logic [2:0]  invalidateIdx = 0, rdIdx = 0, flagClr = 0;
  logic [7:0]  validMap;
  logic [1:0]  keySize;
  logic        rdBusy, coreKeyWe, wrErr, rdErr, resultAvail;
  logic [2:0]  coreKeyIdx;
  logic [31:0] coreKeyData;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0]  refValid = 0;
  logic [1:0]  refSize = 0;
  logic [31:0] refKey [8][8];

  always #4 clk = ~clk;

  keystore_top dut_i (
    .clk(clk), .rstN(rstN), .keySizeWe(keySizeWe), .keySizeIn(keySizeIn),
    .wrAreaWe(wrAreaWe), .wrArea(wrArea), .inValid(inValid), .inData(inData),
    .inLast(inLast), .invalidateWe(invalidateWe), .invalidateIdx(invalidateIdx),
    .rdStartWe(rdStartWe), .rdIdx(rdIdx), .flagClr(flagClr), .validMap(validMap),
    .keySize(keySize), .rdBusy(rdBusy), .coreKeyWe(coreKeyWe), .coreKeyIdx(coreKeyIdx),
    .coreKeyData(coreKeyData), .wrErr(wrErr), .rdErr(rdErr), .resultAvail(resultAvail)
  );

  function automatic int wordsFor(logic [1:0] sz);
    return (sz == 2'd0) ? 4 : 8;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearFlags();
    flagClr = 3'b111;
    @(negedge clk);
    flagClr = 3'b000;
  endtask

  // select, then send n words; last flag on the final word
  task automatic writeKey(input int slot, input int n, input string req);
    int  need = wordsFor(refSize);
    bit  ok = (n == need);
    clearFlags();
    wrAreaWe = 1; wrArea = 8'(1 << slot);
    @(negedge clk);
    wrAreaWe = 0;
    refValid[slot] = 1'b0;
    chk({req, " select clears valid (R2)"}, 32'(validMap), 32'(refValid));
    for (int w = 0; w < n; w++) begin
      inValid = 1; inData = $urandom; inLast = (w == n - 1);
      if (ok) refKey[slot][w] = (refSize == 2'd1 && w >= 6) ? 32'h0 : inData;
      @(negedge clk);
    end
    inValid = 0; inLast = 0;
    if (ok) refValid[slot] = 1'b1;
    chk({req, " valid map"}, 32'(validMap), 32'(refValid));
    chk({req, " wrErr"}, 32'(wrErr), 32'(!ok));
    chk({req, " resultAvail"}, 32'(resultAvail), 32'(ok));
  endtask

  // read slot; optional second start during the transfer (R9)
  task automatic readSlot(input int slot, input bit poke, input string req);
    int n = wordsFor(refSize);
    clearFlags();
    rdStartWe = 1; rdIdx = 3'(slot);
    @(negedge clk);
    rdStartWe = 0;
    if (refValid[slot]) begin
      for (int w = 0; w < n; w++) begin
        chk({req, " busy"}, 32'(rdBusy), 32'd1);
        chk({req, " core we"}, 32'(coreKeyWe), 32'd1);
        chk({req, " core idx"}, 32'(coreKeyIdx), 32'(w));
        chk({req, " core data"}, coreKeyData, refKey[slot][w]);
        if (poke && w == 1) begin rdStartWe = 1; rdIdx = 3'(slot ^ 1); end
        @(negedge clk);
        rdStartWe = 0;
      end
      chk({req, " busy end"}, 32'(rdBusy), 32'd0);
      chk({req, " no rdErr"}, 32'(rdErr), 32'd0);
    end else begin
      chk({req, " R8 rdErr"}, 32'(rdErr), 32'd1);
      chk({req, " R8 no busy"}, 32'({rdBusy, coreKeyWe}), 32'd0);
    end
  endtask

  task automatic invalidateSlot(input int slot, input string req);
    invalidateWe = 1; invalidateIdx = 3'(slot);
    @(negedge clk);
    invalidateWe = 0;
    refValid[slot] = 1'b0;
    chk(req, 32'(validMap), 32'(refValid));
  endtask

  task automatic setSize(input logic [1:0] sz, input string req);
    keySizeWe = 1; keySizeIn = sz;
    @(negedge clk);
    keySizeWe = 0;
    refValid = '0; refSize = sz;
    chk({req, " wipe"}, 32'(validMap), 32'd0);
    chk({req, " size"}, 32'(keySize), 32'(sz));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 validMap", 32'(validMap), 32'd0);
    chk("R1 keySize", 32'(keySize), 32'd0);
    chk("R1 busy/we", 32'({rdBusy, coreKeyWe}), 32'd0);
    chk("R1 flags", 32'({wrErr, rdErr, resultAvail}), 32'd0);

    // R2 128-bit write and R7 read
    writeKey(3, 4, "R2 128-bit");
    readSlot(3, 0, "R7 128-bit read");
    writeKey(3, 4, "R2 rewrite valid slot");

    // R3 192-bit padding (size change also R5)
    setSize(2'd1, "R5 to 192");
    writeKey(5, 8, "R3 192-bit");
    readSlot(5, 0, "R3 192-bit read");

    // R4 length errors and orphan words
    writeKey(1, 6, "R4 early last");
    writeKey(1, 9, "R4 missing last");
    clearFlags();
    wrAreaWe = 1; wrArea = 8'b0000_0011;
    @(negedge clk);
    wrAreaWe = 0; inValid = 1; inLast = 1; inData = 32'hdead_beef;
    @(negedge clk);
    inValid = 0; inLast = 0;
    chk("R4 not one-hot wrErr", 32'(wrErr), 32'd1);
    chk("R4 not one-hot map", 32'(validMap), 32'(refValid));

    // R6 invalidate
    writeKey(2, 8, "R2 192 second slot");
    invalidateSlot(5, "R6 invalidate one");
    invalidateSlot(5, "R6 invalidate again");
    chk("R6 other slot kept", 32'(validMap[2]), 32'd1);

    // R8 read invalid, R9 start during busy
    readSlot(5, 0, "R8 invalid read");
    readSlot(2, 1, "R9 poke during busy");

    // R10 set beats clear, then clear
    clearFlags();
    rdStartWe = 1; rdIdx = 3'd7; flagClr = 3'b010;
    @(negedge clk);
    rdStartWe = 0; flagClr = 3'b000;
    chk("R10 set wins", 32'(rdErr), 32'd1);
    flagClr = 3'b010;
    @(negedge clk);
    flagClr = 3'b000;
    chk("R10 clear rdErr", 32'(rdErr), 32'd0);

    // R5 size change mid-write aborts it
    setSize(2'd2, "R5 to 256");
    writeKey(4, 8, "R2 256-bit");
    clearFlags();
    wrAreaWe = 1; wrArea = 8'b0100_0000;
    @(negedge clk);
    wrAreaWe = 0;
    refValid[6] = 1'b0;
    for (int w = 0; w < 2; w++) begin inValid = 1; inData = $urandom; @(negedge clk); end
    inValid = 0;
    setSize(2'd2, "R5 mid-write");
    for (int w = 0; w < 6; w++) begin inValid = 1; inLast = (w == 5); @(negedge clk); end
    inValid = 0; inLast = 0;
    chk("R5 aborted write wrErr", 32'(wrErr), 32'd1);
    chk("R5 aborted write map", 32'(validMap), 32'd0);

    // random mix
    for (int it = 0; it < 80; it++) begin
      int op = $urandom_range(0, 9);
      int s  = $urandom_range(0, 7);
      if (op < 4) writeKey(s, wordsFor(refSize), "R2 random write");
      else if (op == 4) begin
        int n = $urandom_range(1, 9);
        if (n == wordsFor(refSize)) n = n - 1;
        writeKey(s, n, "R4 random bad length");
      end
      else if (op < 8) readSlot(s, 0, "R7 random read");
      else if (op == 8) invalidateSlot(s, "R6 random invalidate");
      else setSize(2'($urandom_range(0, 3)), "R5 random size");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule